// File: doc/BRIEF.md
# Pin Change Serial Config Controller

This block watches eight static mode-control lines and keeps a radio's internal configuration register in step with them. Each line is synchronised to the system clock. When any synchronised line differs from the value last sent, the block issues a full 8-bit register write over a three-wire serial port. The port has a chip select, a serial clock and a data line that the controller can tri-state.

The power-up mode is sampled from `legacy_mode` while reset is held.

- **Serial mode:** the block stays dormant until the wake input has been seen high. From then on it owns the serial lines. It first writes the current vector, and then writes again after every change.
- **Legacy mode:** the block never drives any of the serial lines. The clock and data wires stay high impedance, so external logic can set them as two static control levels. The clock/data pairs 00, 10, 01 and 11 select sleep, transmit OOK, transmit ASK and receive.

The serial clock is divided from the system clock. Its half-period, in system clock cycles, is set by a port. The radio captures each bit on a rising serial clock edge, so the controller changes data only while the serial clock is low.

Top module: `pinscan_cfg_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `cs_o`, `sclk_o`, `sclk_oe`, `sdata_oe`, `busy` and `done` are all 0.
- R2: If `legacy_mode` is 1 while reset is held, then until the next reset `cs_o`, `sclk_oe` and `sdata_oe` stay 0, whatever `wake` and `ctrl_lines` do.
- R3: In serial mode (`legacy_mode` 0 during reset), no transfer starts and both enables stay 0 until `wake` has been seen high.
- R4: After wake, one transfer is issued, carrying the current `ctrl_lines` value, even if that value is unchanged since reset.
- R5: Each transfer sends the synchronised `ctrl_lines` vector as exactly 8 rising `sclk_o` edges within one `cs_o` high window, bit 7 first. A new transfer starts only when the vector differs from the value last sent.
- R6: `sdata_o` never changes while `sclk_o` is high inside a transfer, so each bit is set up before its rising edge.
- R7: While `cs_o` is high, every low and high phase of `sclk_o` lasts exactly H system cycles. This includes the phase from `cs_o` rising to the first rising edge and from the last falling edge to `cs_o` falling. H is the `half_period` value sampled at transfer start, and 0 is treated as 1.
- R8: If `ctrl_lines` changes during a transfer, that transfer completes unaltered. A second transfer then carries the newest vector.
- R9: `busy` equals `cs_o`. `done` is high for exactly one cycle, the first cycle in which `cs_o` is low after a transfer.
- R10: After wake in serial mode, `sclk_oe` and `sdata_oe` are 1, and `sclk_o` is 0 whenever `cs_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; `legacy_mode` is sampled while it is high |
| legacy_mode | input | 1 | 1 selects legacy pass-through mode, 0 selects serial mode |
| wake | input | 1 | Wake request; arms serial mode once seen high |
| half_period | input | 8 | Serial clock half-period in system cycles (0 acts as 1) |
| ctrl_lines | input | 8 | Mode-control level inputs, asynchronous |
| cs_o | output | 1 | Serial chip select, active high |
| sclk_o | output | 1 | Serial clock value |
| sclk_oe | output | 1 | Output enable for the serial clock wire |
| sdata_o | output | 1 | Serial data value |
| sdata_oe | output | 1 | Output enable for the serial data wire |
| busy | output | 1 | High while a transfer is framed |
| done | output | 1 | One-cycle pulse at the end of each transfer |

## Verification
The assertions assume that `legacy_mode` changes only while reset is held. They also assume that `half_period` is not changed in the cycle a transfer starts, so that each transfer runs at one phase length. The bench changes `half_period` and `legacy_mode` only while the block is idle or in reset. It draws line vectors from a seeded `$urandom` and forces each to differ from the previous one. A monitor checks the timing and every captured byte against the vector the bench last applied.

// File: rtl/pinscan_pkg.sv
package pinscan_pkg;

    localparam int LINE_W = 8;
    localparam int HALF_W = 8;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH,
        SH_TAIL
    } shift_state_t;

    typedef struct packed {
        logic cs;
        logic sclk;
        logic sdo;
    } wire_drive_t;

    function automatic logic [HALF_W-1:0] phase_limit(input logic [HALF_W-1:0] h);
        // number of cycles minus one that a clock phase lasts
        return (h == '0) ? '0 : h - 1'b1;
    endfunction

endpackage

// File: rtl/pinscan_sync.sv
module pinscan_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_in[i];
                stab_q <= meta_q;
            end
        end
        assign sync_out[i] = stab_q;
    end
endmodule

// File: rtl/pinscan_trigger.sv
module pinscan_trigger #(
    parameter int W = pinscan_pkg::LINE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         legacy_in,
    input  logic         wake_s,
    input  logic [W-1:0] lines_s,
    input  logic         engine_idle,
    output logic         start,
    output logic         own,
    output logic         legacy_q
);
    logic         awake_q;
    logic [W-1:0] sent_q;
    logic         sent_valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            legacy_q     <= legacy_in;
            awake_q      <= 1'b0;
            sent_q       <= '0;
            sent_valid_q <= 1'b0;
        end else begin
            if (wake_s && !legacy_q) begin
                awake_q <= 1'b1;
            end
            if (start) begin
                sent_q       <= lines_s;
                sent_valid_q <= 1'b1;
            end
        end
    end

    assign own   = awake_q;
    assign start = awake_q && engine_idle && (!sent_valid_q || (lines_s != sent_q));
endmodule

// File: rtl/pinscan_shifter.sv
module pinscan_shifter
    import pinscan_pkg::*;
#(
    parameter int W = LINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [W-1:0]      vec,
    input  logic [HALF_W-1:0] half,
    output logic              idle,
    output wire_drive_t       drive,
    output logic              done
);
    localparam int BIT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(W - 1);

    shift_state_t      state_q;
    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] lim_q;
    logic [BIT_W-1:0]  bit_q;
    logic [W-1:0]      shreg_q;
    logic              cs_q;
    logic              sclk_q;
    logic              done_q;
    logic              phase_end;

    assign phase_end = (cnt_q == lim_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SH_IDLE;
            cnt_q   <= '0;
            lim_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
            cs_q    <= 1'b0;
            sclk_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SH_IDLE: begin
                    if (start) begin
                        shreg_q <= vec;
                        lim_q   <= phase_limit(half);
                        cnt_q   <= '0;
                        bit_q   <= '0;
                        cs_q    <= 1'b1;
                        sclk_q  <= 1'b0;
                        state_q <= SH_LOW;
                    end
                end
                SH_LOW: begin
                    if (phase_end) begin
                        cnt_q   <= '0;
                        sclk_q  <= 1'b1;
                        state_q <= SH_HIGH;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SH_HIGH: begin
                    if (phase_end) begin
                        cnt_q  <= '0;
                        sclk_q <= 1'b0;
                        if (bit_q == LAST_BIT) begin
                            state_q <= SH_TAIL;
                        end else begin
                            bit_q   <= bit_q + 1'b1;
                            shreg_q <= {shreg_q[W-2:0], 1'b0};
                            state_q <= SH_LOW;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SH_TAIL: begin
                    if (phase_end) begin
                        cnt_q   <= '0;
                        cs_q    <= 1'b0;
                        done_q  <= 1'b1;
                        state_q <= SH_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SH_IDLE;
            endcase
        end
    end

    assign idle       = (state_q == SH_IDLE);
    assign drive.cs   = cs_q;
    assign drive.sclk = sclk_q;
    assign drive.sdo  = shreg_q[W-1];
    assign done       = done_q;
endmodule

// File: rtl/pinscan_cfg_ctrl.sv
module pinscan_cfg_ctrl
    import pinscan_pkg::*;
#(
    parameter int W = LINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              legacy_mode,
    input  logic              wake,
    input  logic [HALF_W-1:0] half_period,
    input  logic [W-1:0]      ctrl_lines,
    output logic              cs_o,
    output logic              sclk_o,
    output logic              sclk_oe,
    output logic              sdata_o,
    output logic              sdata_oe,
    output logic              busy,
    output logic              done
);
    logic [W:0]   sync_vec;
    logic [W-1:0] lines_s;
    logic         wake_s;
    logic         start;
    logic         own;
    logic         legacy_q;
    logic         engine_idle;
    wire_drive_t  drive;

    pinscan_sync #(.W(W + 1)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({wake, ctrl_lines}),
        .sync_out (sync_vec)
    );

    assign lines_s = sync_vec[W-1:0];
    assign wake_s  = sync_vec[W];

    pinscan_trigger #(.W(W)) u_trig (
        .clk         (clk),
        .rst         (rst),
        .legacy_in   (legacy_mode),
        .wake_s      (wake_s),
        .lines_s     (lines_s),
        .engine_idle (engine_idle),
        .start       (start),
        .own         (own),
        .legacy_q    (legacy_q)
    );

    pinscan_shifter #(.W(W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .vec   (lines_s),
        .half  (half_period),
        .idle  (engine_idle),
        .drive (drive),
        .done  (done)
    );

    assign cs_o     = drive.cs;
    assign sclk_o   = drive.sclk;
    assign sdata_o  = drive.sdo;
    assign sclk_oe  = own;
    assign sdata_oe = own;
    assign busy     = drive.cs;
endmodule

// File: rtl/pinscan_cfg_ctrl_chk.sv
module pinscan_cfg_ctrl_chk #(
    parameter int W = 8
) (
    input logic clk,
    input logic rst,
    input logic legacy_q,
    input logic own,
    input logic cs_o,
    input logic sclk_o,
    input logic sdata_o,
    input logic sclk_oe,
    input logic sdata_oe,
    input logic done
);
    localparam int PC_W = $clog2(W + 1) + 1;

    logic [PC_W-1:0] pulse_cnt;
    logic            sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_cnt <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= sclk_o;
            if (done) begin
                pulse_cnt <= '0;
            end else if (cs_o && sclk_o && !sclk_prev) begin
                pulse_cnt <= pulse_cnt + 1'b1;
            end
        end
    end

    AST_LEGACY_QUIET: assert property (@(posedge clk) disable iff (rst)
        legacy_q |-> (!cs_o && !sclk_oe && !sdata_oe)); // R2

    AST_DORMANT_NO_FRAME: assert property (@(posedge clk) disable iff (rst)
        !own |-> !cs_o); // R3

    AST_EIGHT_PULSES: assert property (@(posedge clk) disable iff (rst)
        done |-> (pulse_cnt == PC_W'(W))); // R5

    AST_BIT_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (cs_o && sclk_o && $past(sclk_o)) |-> $stable(sdata_o)); // R6

    AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
        done |-> $fell(cs_o)); // R9

    AST_FRAME_END_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_o) |-> done); // R9

    AST_CLK_PARKED_LOW: assert property (@(posedge clk) disable iff (rst)
        !cs_o |-> !sclk_o); // R10
endmodule

bind pinscan_cfg_ctrl pinscan_cfg_ctrl_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .legacy_q (legacy_q),
    .own      (own),
    .cs_o     (cs_o),
    .sclk_o   (sclk_o),
    .sdata_o  (sdata_o),
    .sclk_oe  (sclk_oe),
    .sdata_oe (sdata_oe),
    .done     (done)
);

// File: tb/tb_pinscan_cfg_ctrl.sv
`timescale 1ns/1ps
module tb_pinscan_cfg_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       legacy_mode = 1'b0;
    logic       wake = 1'b0;
    logic [7:0] half_period = 8'd2;
    logic [7:0] ctrl_lines = 8'h00;
    logic cs_o, sclk_o, sclk_oe, sdata_o, sdata_oe, busy, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinscan_cfg_ctrl dut (
        .clk(clk), .rst(rst), .legacy_mode(legacy_mode), .wake(wake),
        .half_period(half_period), .ctrl_lines(ctrl_lines),
        .cs_o(cs_o), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sdata_o(sdata_o),
        .sdata_oe(sdata_oe), .busy(busy), .done(done)
    );

    // ---------------- monitor ----------------
    logic [7:0] xfer_log [0:63];
    int   xfer_n, bad_width, bad_setup, bad_done, bad_bits, bad_busy, drive_seen, run;
    logic p_cs, p_sclk, p_sdo;
    logic [7:0] acc;
    int   nbits;

    function automatic int exp_half(input logic [7:0] h);
        return (h == 8'd0) ? 1 : int'(h);
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            xfer_n = 0; bad_width = 0; bad_setup = 0; bad_done = 0;
            bad_bits = 0; bad_busy = 0; drive_seen = 0; run = 0;
            p_cs = 0; p_sclk = 0; p_sdo = 0; acc = 0; nbits = 0;
        end else begin
            if (cs_o && !p_cs) begin acc = 8'h00; nbits = 0; end
            if (cs_o && sclk_o && !p_sclk) begin acc = {acc[6:0], sdata_o}; nbits++; end
            if (p_cs && cs_o && sclk_o && p_sclk && sdata_o != p_sdo) bad_setup++;
            if ({cs_o, sclk_o} == {p_cs, p_sclk}) run++;
            else begin
                if (p_cs && run != exp_half(half_period)) bad_width++;
                run = 1;
            end
            if (done != (p_cs && !cs_o)) bad_done++;
            if (busy != cs_o) bad_busy++;
            if (p_cs && !cs_o) begin
                if (nbits != 8) bad_bits++;
                if (xfer_n < 64) xfer_log[xfer_n] = acc;
                xfer_n++;
            end
            if (cs_o || sclk_oe || sdata_oe) drive_seen++;
            p_cs = cs_o; p_sclk = sclk_o; p_sdo = sdata_o;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_xfers(input int target, input int limit);
        for (int i = 0; i < limit && xfer_n < target; i++) step(1);
        step(3);
    endtask

    task automatic do_reset(input logic leg);
        @(posedge clk); #1;
        rst = 1'b1; legacy_mode = leg; wake = 1'b0;
        step(3);
        rst = 1'b0;
    endtask

    function automatic logic [7:0] fresh(input logic [7:0] old);
        logic [7:0] v;
        v = 8'($urandom);
        if (v == old) v = ~old;
        return v;
    endfunction

    // ---------------- stimulus ----------------
    initial begin
        int seed_sink;
        int base;
        logic [7:0] a, b;
        seed_sink = $urandom(32'h5EED_0042);

        // R1: reset state
        do_reset(1'b0);
        @(negedge clk);
        check(!cs_o && !sclk_o && !busy && !done, "R1 frame/clk idle", {cs_o, sclk_o, busy, done}, 0);
        check(!sclk_oe && !sdata_oe, "R1 enables low", {sclk_oe, sdata_oe}, 0);

        // R3: dormant before wake
        for (int i = 0; i < 6; i++) begin
            ctrl_lines = fresh(ctrl_lines);
            step(15);
        end
        check(xfer_n == 0, "R3 no transfer before wake", xfer_n, 0);
        check(drive_seen == 0, "R3 no driving before wake", drive_seen, 0);

        // R4: initial write after wake, value unchanged since last edit
        half_period = 8'd3;
        wake = 1'b1;
        wait_xfers(1, 400);
        check(xfer_n == 1, "R4 one transfer after wake", xfer_n, 1);
        check(xfer_log[0] == ctrl_lines, "R4 initial vector", xfer_log[0], ctrl_lines);
        @(negedge clk);
        check(sclk_oe && sdata_oe, "R10 lines owned after wake", {sclk_oe, sdata_oe}, 3);

        // R5/R7: random changes with random half periods, including 0
        for (int i = 0; i < 20; i++) begin
            base = xfer_n;
            half_period = (i == 0) ? 8'd0 : (i == 1) ? 8'd1 : 8'($urandom_range(0, 5));
            ctrl_lines = fresh(ctrl_lines);
            wait_xfers(base + 1, 400);
            step(10);
            check(xfer_n == base + 1, "R5 one transfer per change", xfer_n - base, 1);
            check(xfer_log[base] == ctrl_lines, "R5 MSB-first byte", xfer_log[base], ctrl_lines);
        end

        // R5: no change -> no transfer
        base = xfer_n;
        ctrl_lines = ctrl_lines;
        step(60);
        check(xfer_n == base, "R5 no transfer without change", xfer_n - base, 0);

        // R8: change during transfer
        half_period = 8'd4;
        a = fresh(ctrl_lines);
        b = fresh(a);
        base = xfer_n;
        ctrl_lines = a;
        for (int i = 0; i < 100 && !cs_o; i++) step(1);
        step(5);
        ctrl_lines = b;
        wait_xfers(base + 2, 800);
        step(20);
        check(xfer_n == base + 2, "R8 two transfers", xfer_n - base, 2);
        check(xfer_log[base] == a, "R8 first transfer unaltered", xfer_log[base], a);
        check(xfer_log[base + 1] == b, "R8 second carries newest", xfer_log[base + 1], b);

        // R6/R7/R9/R5 monitor tallies over the serial phase
        check(bad_setup == 0, "R6 data held while clock high", bad_setup, 0);
        check(bad_width == 0, "R7 phase lengths", bad_width, 0);
        check(bad_done == 0, "R9 done pulse placement", bad_done, 0);
        check(bad_busy == 0, "R9 busy equals frame", bad_busy, 0);
        check(bad_bits == 0, "R5 eight clock pulses", bad_bits, 0);
        @(negedge clk);
        check(!cs_o && !sclk_o, "R10 clock parked low", {cs_o, sclk_o}, 0);

        // R2: legacy mode never drives
        do_reset(1'b1);
        wake = 1'b1;
        for (int i = 0; i < 12; i++) begin
            half_period = 8'($urandom_range(0, 4));
            ctrl_lines = fresh(ctrl_lines);
            step(20);
        end
        check(drive_seen == 0, "R2 legacy lines released", drive_seen, 0);
        check(xfer_n == 0, "R2 legacy no transfer", xfer_n, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule